// File: doc/BRIEF.md
# SONET Frame Alignment Detector

This block sits behind a 1:4 deserializer and finds the byte and frame boundaries of a SONET stream. It gets one 4-bit nibble per clock, and bit 0 of each nibble is the earliest bit on the line. The block tests all four bit positions inside every nibble for the framing word: three A1 bytes followed by one A2 byte. When it finds a candidate, it stores that bit position. It then expects the same word at the same position once every frame period, counted in nibble clocks.

The block declares frame alignment after the third matching word. At that point it raises an in-frame flag and gives a frame-sync pulse four clocks wide. From then on it sends out nibbles re-cut on the stored boundary. While it is aligned, a framing word seen anywhere other than the expected position has no effect. Alignment is dropped after a run of missed expected positions. A frame-enable input freezes all acquisition and keeps the last boundary found.

Top module: `frame_aligner`

## Requirements
- R1: After a clock edge with `rst_n` low (synchronous reset), `data_valid` is 0, `frame_sync` is 0 and `al_nib` is 4'h0.
- R2: The framing word is the 32-bit serial sequence F6 F6 F6 28 (hex), each byte sent MSB first. Serial order is `rx_nib[0]` first, then `rx_nib[3:1]` in turn, across consecutive nibbles. The word is recognised at any of the four bit positions within a nibble.
- R3: Alignment needs three framing words, each exactly `FRAME_NIBS` nibble clocks after the one before. If the expected position misses before the third word, the search starts again.
- R4: `data_valid` stays 0 while searching and confirming. It goes to 1 on the clock edge that takes in the nibble holding the last bit of the third word.
- R5: `frame_sync` rises on that same edge and stays high for exactly 4 clocks.
- R6: While aligned, `al_nib` shows, one clock after nibble k is taken in, the four serial bits ending at the locked boundary bit e within nibble k. That is, stream bits 4k+e-3 .. 4k+e, with the earliest bit in `al_nib[0]`.
- R7: While aligned, a framing word at any other position changes neither the boundary nor `data_valid`.
- R8: Alignment is lost (`data_valid` falls) only after 4 consecutive expected positions without the word. Fewer misses followed by a hit keep it.
- R9: While `frame_en` is 0, there is no acquisition, no frame counting and no loss. The boundary found earlier keeps being used to cut `al_nib`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_en | input | 1 | 1 lets the aligner search and track; 0 freezes it |
| rx_nib | input | 4 | Deserialized nibble, bit 0 earliest |
| al_nib | output | 4 | Nibble re-cut on the locked boundary, bit 0 earliest |
| data_valid | output | 1 | In-frame flag |
| frame_sync | output | 1 | Four-clock pulse when alignment is declared |

## Verification
The assertions assume that `rst_n` is low for the first clock edges. They also assume that `frame_en` is changed only between frames, so that a frozen tracker never sees half a frame. The bench drives `frame_en` only at frame boundaries, after reset. Payload bits are random from a fixed seed. Given the 32-bit framing word, an accidental match is too unlikely to spoil a run. Deliberate mimics and shifted or missing words are placed only where each scenario calls for them.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int NIB_W = 4;
  localparam int PAT_W = 32;
  localparam int WIN_W = PAT_W + NIB_W - 1;
  localparam int OFF_W = $clog2(NIB_W);
  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;
  localparam logic [PAT_W-1:0] FRAME_WORD = {A1_BYTE, A1_BYTE, A1_BYTE, A2_BYTE};

  typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_LOCKED} fa_state_e;

  // lowest offset with a hit wins
  function automatic logic [OFF_W-1:0] lowest_hit(input logic [NIB_W-1:0] v);
    logic [OFF_W-1:0] r;
    r = '0;
    for (int i = NIB_W - 1; i >= 0; i--)
      if (v[i]) r = OFF_W'(i);
    return r;
  endfunction

  // window bit 0 is newest; result bit 0 is earliest of the four
  function automatic logic [NIB_W-1:0] take_nibble(input logic [WIN_W-1:0] w,
                                                   input logic [OFF_W-1:0] off);
    logic [NIB_W-1:0] r;
    for (int i = 0; i < NIB_W; i++)
      r[i] = w[int'(off) + NIB_W - 1 - i];
    return r;
  endfunction
endpackage

// File: rtl/fa_window.sv
module fa_window
  import fa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] rx_nib,
  output logic [WIN_W-1:0] win,
  output logic [NIB_W-1:0] hit
);
  localparam int HIST_W = PAT_W - 1;

  logic [HIST_W-1:0] hist;

  always_comb begin
    win[WIN_W-1:NIB_W] = hist;
    for (int i = 0; i < NIB_W; i++)
      win[NIB_W-1-i] = rx_nib[i];
  end

  for (genvar o = 0; o < NIB_W; o++) begin : g_cmp
    assign hit[o] = (win[o+PAT_W-1 -: PAT_W] == FRAME_WORD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= win[HIST_W-1:0];
  end
endmodule

// File: rtl/fa_tracker.sv
module fa_tracker
  import fa_pkg::*;
#(
  parameter int FRAME_NIBS = 9720,
  parameter int HITS_REQ   = 3,
  parameter int MISS_MAX   = 4,
  parameter int SYNC_LEN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en,
  input  logic [NIB_W-1:0] hit,
  output logic [OFF_W-1:0] lock_off,
  output logic             in_sync,
  output logic             fsync,
  output logic             exp_point,
  output logic             exp_hit
);
  localparam int CNT_W = $clog2(FRAME_NIBS);
  localparam int HIT_W = $clog2(HITS_REQ + 1);
  localparam int MIS_W = $clog2(MISS_MAX + 1);
  localparam int FS_W  = $clog2(SYNC_LEN + 1);

  fa_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [HIT_W-1:0] hits;
  logic [MIS_W-1:0] misses;
  logic [FS_W-1:0]  fs_cnt;

  assign exp_point = (cnt == CNT_W'(FRAME_NIBS - 1));
  assign exp_hit   = hit[lock_off];
  assign in_sync   = (state == ST_LOCKED);
  assign fsync     = (fs_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      hits     <= '0;
      misses   <= '0;
      fs_cnt   <= '0;
      lock_off <= '0;
    end else begin
      if (fs_cnt != '0) fs_cnt <= fs_cnt - 1'b1;
      if (frame_en) begin
        case (state)
          ST_HUNT: begin
            if (|hit) begin
              lock_off <= lowest_hit(hit);
              cnt      <= '0;
              hits     <= HIT_W'(1);
              state    <= ST_CONFIRM;
            end
          end
          ST_CONFIRM: begin
            if (exp_point) begin
              cnt <= '0;
              if (!exp_hit) state <= ST_HUNT;
              else if (hits == HIT_W'(HITS_REQ - 1)) begin
                state  <= ST_LOCKED;
                misses <= '0;
                fs_cnt <= FS_W'(SYNC_LEN);
              end else hits <= hits + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_LOCKED: begin
            if (exp_point) begin
              cnt <= '0;
              if (exp_hit) misses <= '0;
              else if (misses == MIS_W'(MISS_MAX - 1)) state <= ST_HUNT;
              else misses <= misses + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/fa_align.sv
module fa_align
  import fa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win,
  input  logic [OFF_W-1:0] lock_off,
  output logic [NIB_W-1:0] al_nib
);
  always_ff @(posedge clk) begin
    if (!rst_n) al_nib <= '0;
    else        al_nib <= take_nibble(win, lock_off);
  end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
#(
  parameter int FRAME_NIBS = 9720,
  parameter int HITS_REQ   = 3,
  parameter int MISS_MAX   = 4,
  parameter int SYNC_LEN   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_en,
  input  logic [3:0] rx_nib,
  output logic [3:0] al_nib,
  output logic       data_valid,
  output logic       frame_sync
);
  logic [WIN_W-1:0] win;
  logic [NIB_W-1:0] hit;
  logic [OFF_W-1:0] lock_off;
  logic             exp_point;
  logic             exp_hit;

  fa_window u_win (
    .clk(clk), .rst_n(rst_n), .rx_nib(rx_nib), .win(win), .hit(hit)
  );

  fa_tracker #(
    .FRAME_NIBS(FRAME_NIBS), .HITS_REQ(HITS_REQ),
    .MISS_MAX(MISS_MAX), .SYNC_LEN(SYNC_LEN)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .hit(hit),
    .lock_off(lock_off), .in_sync(data_valid), .fsync(frame_sync),
    .exp_point(exp_point), .exp_hit(exp_hit)
  );

  fa_align u_aln (
    .clk(clk), .rst_n(rst_n), .win(win), .lock_off(lock_off), .al_nib(al_nib)
  );
endmodule

// File: rtl/fa_checker.sv
module fa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_en,
  input logic       data_valid,
  input logic       frame_sync,
  input logic [1:0] lock_off,
  input logic       exp_point,
  input logic       exp_hit
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!data_valid && !frame_sync)); // R1

  AST_SYNC_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync) |-> $rose(data_valid)); // R4

  AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync) |=> frame_sync ##1 frame_sync ##1 frame_sync ##1 !frame_sync); // R5

  AST_BOUNDARY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid)) |-> $stable(lock_off)); // R7

  AST_HIT_KEEPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && data_valid && exp_point && exp_hit) |=> data_valid); // R8

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> $stable(lock_off)); // R9

  AST_NO_ACQUIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_en && !data_valid) |=> !data_valid); // R9
endmodule

bind frame_aligner fa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .data_valid(data_valid),
  .frame_sync(frame_sync), .lock_off(lock_off), .exp_point(exp_point),
  .exp_hit(exp_hit)
);

// File: tb/sim_frame_aligner.sv
`timescale 1ns/1ps
module sim_frame_aligner;
  localparam int FN = 48;
  localparam int FB = FN * 4;
  localparam logic [31:0] WORD = 32'hF6F6F628;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_en = 1'b1;
  logic [3:0] rx_nib = 4'h0;
  logic [3:0] al_nib;
  logic data_valid, frame_sync;

  int n_chk = 0, n_fail = 0;
  logic sbits [0:32767];
  logic fb [0:FB-1];
  int gbit = 0;
  int fs_first, fs_len, align_err;
  logic last_valid;

  always #10 clk = ~clk;

  frame_aligner #(.FRAME_NIBS(FN)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .rx_nib(rx_nib),
    .al_nib(al_nib), .data_valid(data_valid), .frame_sync(frame_sync)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected nibble for boundary bit j of nibble k
  function automatic logic [3:0] exp_nib(input int k, input int j);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = sbits[4*k + j - 3 + i];
    return r;
  endfunction

  task automatic push(input logic [3:0] n);
    for (int i = 0; i < 4; i++) sbits[gbit + i] = n[i];
    rx_nib = n;
    @(posedge clk);
    #1;
    gbit += 4;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    push(4'h0);
    push(4'h0);
    check(!data_valid && !frame_sync && al_nib == 4'h0, "R1 reset state",
          {data_valid, frame_sync, al_nib}, 0);
    rst_n = 1'b1;
  endtask

  task automatic send_frame(input int pe, input int pe2, input int jref, input bit chk);
    logic [3:0] n;
    int k;
    for (int b = 0; b < FB; b++) fb[b] = 1'($urandom);
    if (pe >= 0)  for (int t = 0; t < 32; t++) fb[pe - 31 + t]  = WORD[31 - t];
    if (pe2 >= 0) for (int t = 0; t < 32; t++) fb[pe2 - 31 + t] = WORD[31 - t];
    fs_first = -1; fs_len = 0; align_err = 0;
    for (int i = 0; i < FN; i++) begin
      n = {fb[4*i+3], fb[4*i+2], fb[4*i+1], fb[4*i]};
      k = gbit / 4;
      push(n);
      if (frame_sync) begin
        if (fs_first < 0) fs_first = i;
        fs_len++;
      end
      if (chk && data_valid && al_nib != exp_nib(k, jref)) align_err++;
    end
    last_valid = data_valid;
  endtask

  task automatic acquire(input int pe);
    do_reset();
    send_frame(pe, -1, 0, 0);
    check(last_valid == 1'b0, "R4 valid low after first word", last_valid, 0);
    send_frame(pe, -1, 0, 0);
    check(last_valid == 1'b0 && fs_first == -1, "R3 no sync after two words", fs_first, -1);
    send_frame(pe, -1, 0, 0);
    check(fs_first == pe / 4, "R2 R4 sync at third word nibble", fs_first, pe / 4);
    check(fs_len == 4, "R5 sync pulse width", fs_len, 4);
    check(last_valid == 1'b1, "R4 valid high when aligned", last_valid, 1);
    send_frame(pe, -1, pe % 4, 1);
    check(align_err == 0, "R6 aligned nibbles", align_err, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // directed offsets j = 1,2,3,0, then random positions
    acquire(37);
    acquire(58);
    acquire(99);
    acquire(120);
    for (int r = 0; r < 3; r++) acquire(31 + int'($urandom % 130));

    // R7 payload mimic at another bit offset
    acquire(37);
    send_frame(37, 107, 1, 1);
    check(last_valid == 1'b1 && align_err == 0, "R7 mimic ignored", align_err, 0);
    send_frame(37, 150, 1, 1);
    check(last_valid == 1'b1 && align_err == 0 && fs_len == 0, "R7 mimic no reframe", fs_len, 0);

    // R8 loss only after four misses
    for (int f = 0; f < 3; f++) send_frame(-1, -1, 1, 0);
    check(last_valid == 1'b1, "R8 three misses tolerated", last_valid, 1);
    send_frame(37, -1, 1, 1);
    check(last_valid == 1'b1 && align_err == 0, "R8 hit restores", align_err, 0);
    for (int f = 0; f < 3; f++) send_frame(-1, -1, 1, 0);
    check(last_valid == 1'b1, "R8 still aligned after three misses", last_valid, 1);
    send_frame(-1, -1, 1, 0);
    check(last_valid == 1'b0, "R8 lost after four misses", last_valid, 0);

    // R3 wrong spacing
    do_reset();
    send_frame(58, -1, 0, 0);
    send_frame(58, -1, 0, 0);
    send_frame(62, -1, 0, 0);
    check(fs_first == -1 && last_valid == 1'b0, "R3 late word no sync", fs_first, -1);
    send_frame(62, -1, 0, 0);
    check(fs_first == -1 && last_valid == 1'b0, "R3 restart counted", last_valid, 0);

    // R9 no acquisition while disabled
    do_reset();
    frame_en = 1'b0;
    for (int f = 0; f < 4; f++) send_frame(99, -1, 0, 0);
    check(fs_first == -1 && last_valid == 1'b0, "R9 no acquire when disabled", last_valid, 0);
    frame_en = 1'b1;

    // R9 boundary frozen
    acquire(58);
    frame_en = 1'b0;
    for (int f = 0; f < 2; f++) send_frame(99, -1, 2, 1);
    check(last_valid == 1'b1 && align_err == 0 && fs_len == 0, "R9 boundary frozen",
          align_err, 0);
    for (int f = 0; f < 5; f++) send_frame(-1, -1, 2, 1);
    check(last_valid == 1'b1 && align_err == 0, "R9 no loss while disabled", last_valid, 1);
    frame_en = 1'b1;

    // R1 reset from aligned state
    do_reset();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule